// File: doc/BRIEF.md
# Heater-Assisted Reference Trim Calibration Sequencer

This block steps a tunable bandgap reference onto a new curve whose curvature minimum sits one segment higher in temperature. It owns two trim codes: an inflection trim, which moves the temperature of the curve's flat point, and a level trim, which shifts the output voltage without moving that point. Each code is found by a successive-approximation search, most significant bit first, one bit per comparator decision. The die temperature is read as a 10-bit sensor code; the only heat source the block controls is an on-die heater enable.

An inflection step samples the reference at the baseline temperature, heats the die by twice the programmed segment span, samples again with the same trial code, and then takes the external comparator verdict on the pair. Before the next trial the die must cool back to the baseline. When every inflection bit is settled, the block waits for the ambient temperature to climb half a span above baseline. It then runs the level search, which compares the output on the old codes against the output on the new inflection code with the trial level code. The new codes go onto the trim outputs only once the sensor reads strictly above that half-span point. If a heating or cooling wait runs past a programmable cycle limit, the run aborts with the heater off.

States: IDLE (waiting for start), I_LO (first sample of an inflection trial), I_HEAT (heater on), I_HI (second sample), I_VERD (waiting for the verdict), I_COOL (waiting for baseline), L_ARM (waiting for the half-span point), L_OLD (sample on the old codes), L_NEW (sample on the new codes), L_VERD (waiting for the level verdict), SWITCH (waiting to pass the half-span point), DONE and ERR. Transitions: start from IDLE, DONE or ERR goes to I_LO. I_LO goes to I_HEAT. I_HEAT goes to I_HI once hot, or to ERR on timeout. I_HI goes to I_VERD. I_VERD goes to I_COOL on a verdict. I_COOL goes to I_LO (bits left) or L_ARM (search finished) once cooled, or to ERR on timeout. L_ARM goes to L_OLD at the half-span point. L_OLD goes to L_NEW, and L_NEW goes to L_VERD. L_VERD goes to L_OLD (bits left) or SWITCH (last bit) on a verdict. SWITCH goes to DONE once the sensor is above the half-span point.

Top module: `refcal_seq`

## Requirements
- R1: A synchronous reset turns the heater off, clears busy, done and err, and drives the trim outputs to the default codes (inflection 8'h5A, level 8'h33).
- R2: When start is seen while not busy, the sensor code is latched as the baseline S0 and busy rises. In the next cycle req_first pulses with the heater off, the inflection trim shows the first trial 8'h80 (MSB set, lower bits clear), and the level trim keeps its previous value.
- R3: The heater stays on until the sensor code is at least S0 + 2*span. It then drops, and req_second pulses with the inflection trial unchanged.
- R4: Each comparator verdict (cmp_valid with cmp_gt) settles the current inflection bit: cmp_gt=1 keeps it at 1 and cmp_gt=0 clears it. The next lower bit is set in the next trial, and nothing advances until cmp_valid arrives.
- R5: After a verdict the heater stays off, and the next trial's req_first comes only once the sensor code is at or below S0.
- R6: After the last inflection bit and the cool-down, no request is issued until the sensor code is at least S0 + floor(span/2). In that wait both trims show the old codes. Each level step then pulses req_first on the old codes, followed by req_second on the new inflection code and the level trial, with the same bit rule as R4.
- R7: After the last level verdict the outputs keep the old codes until the sensor code is strictly above S0 + floor(span/2). Then both new codes are driven, done rises and busy falls.
- R8: If a heating or cooling wait is still unmet after tmo_lim+1 cycles in that state, err rises, the heater turns off, busy falls, and the trims return to the codes applied before the run.
- R9: req_first and req_second are single-cycle pulses, never high together, and never high while the heater is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a calibration run |
| sens_code | input | 10 | Temperature sensor ADC code |
| span | input | 10 | Sensor delta for one segment span |
| tmo_lim | input | 16 | Cycle limit for heating and cooling waits |
| cmp_valid | input | 1 | Comparator verdict strobe |
| cmp_gt | input | 1 | Verdict: 1 keeps the trial bit |
| infl_trim | output | 8 | Inflection trim code to the reference |
| lvl_trim | output | 8 | Level trim code to the reference |
| heat_en | output | 1 | Heater enable |
| req_first | output | 1 | Request capture of the first sample |
| req_second | output | 1 | Request capture of the second sample and a verdict |
| busy | output | 1 | Run in progress |
| done | output | 1 | New codes applied |
| err | output | 1 | Run aborted on timeout |

## Verification
The searches run against a behavioural comparator that keeps a trial bit whenever the trial code does not exceed a hidden target. Extreme targets (all ones, all zeros) show whether the bit-keep and bit-clear paths each act alone. Random targets, baselines and odd or even spans show whether the two searches stay independent of each other and of the threshold arithmetic. A thermal model that heats and cools one code per cycle paces every step. Ambient is held exactly at the half-span point to tell the "reach" threshold apart from the "pass" threshold. A dead heater exposes the timeout path, and a reset in mid-heat shows the defaults being restored.

// File: rtl/refcal_pkg.sv
package refcal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_I_LO,
        ST_I_HEAT,
        ST_I_HI,
        ST_I_VERD,
        ST_I_COOL,
        ST_L_ARM,
        ST_L_OLD,
        ST_L_NEW,
        ST_L_VERD,
        ST_SWITCH,
        ST_DONE,
        ST_ERR
    } cal_state_t;

endpackage

// File: rtl/trim_sar.sv
module trim_sar #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic         step,
    input  logic         keep,
    output logic [W-1:0] code,
    output logic         last
);
    localparam logic [W-1:0] TOP = W'(1) << (W - 1);

    logic [W-1:0] code_q;
    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (init) begin
            code_q <= TOP;
            mask_q <= TOP;
        end else if (step && (mask_q != '0)) begin
            code_q <= (keep ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
            mask_q <= mask_q >> 1;
        end
    end

    assign code = code_q;
    assign last = mask_q[0];
endmodule

// File: rtl/sens_thresh.sv
module sens_thresh #(
    parameter int SENS_W = 10
) (
    input  logic [SENS_W-1:0] s0,
    input  logic [SENS_W-1:0] span,
    input  logic [SENS_W-1:0] sens,
    output logic              hot_reached,
    output logic              cooled,
    output logic              mid_reached,
    output logic              mid_passed
);
    localparam int XW = SENS_W + 2;

    logic [XW-1:0] s0x, spx, sx, hot_lvl, mid_lvl;

    always_comb begin
        s0x         = XW'(s0);
        spx         = XW'(span);
        sx          = XW'(sens);
        hot_lvl     = s0x + (spx << 1);
        mid_lvl     = s0x + (spx >> 1);
        hot_reached = sx >= hot_lvl;
        cooled      = sens <= s0;
        mid_reached = sx >= mid_lvl;
        mid_passed  = sx > mid_lvl;
    end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] lim,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = en && (cnt_q >= lim);
endmodule

// File: rtl/refcal_seq.sv
module refcal_seq
    import refcal_pkg::*;
#(
    parameter int                TRIM_W   = 8,
    parameter int                SENS_W   = 10,
    parameter int                TMO_W    = 16,
    parameter logic [TRIM_W-1:0] DEF_INFL = 8'h5A,
    parameter logic [TRIM_W-1:0] DEF_LVL  = 8'h33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SENS_W-1:0] sens_code,
    input  logic [SENS_W-1:0] span,
    input  logic [TMO_W-1:0]  tmo_lim,
    input  logic              cmp_valid,
    input  logic              cmp_gt,
    output logic [TRIM_W-1:0] infl_trim,
    output logic [TRIM_W-1:0] lvl_trim,
    output logic              heat_en,
    output logic              req_first,
    output logic              req_second,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int N_SAR = 2;
    localparam int IX_I  = 0;
    localparam int IX_L  = 1;

    cal_state_t        state_q, state_d;
    logic [SENS_W-1:0] s0_q;
    logic [TRIM_W-1:0] cur_infl_q, cur_lvl_q;
    logic              infl_fin_q;
    logic              idle_like, go;

    logic [N_SAR-1:0]  sar_init, sar_step, sar_last;
    logic [TRIM_W-1:0] sar_code [N_SAR];

    logic hot_reached, cooled, mid_reached, mid_passed;
    logic tmr_en, tmr_clr, tmo;

    for (genvar g = 0; g < N_SAR; g++) begin : g_sar
        trim_sar #(.W(TRIM_W)) u_sar (
            .clk  (clk),
            .rst  (rst),
            .init (sar_init[g]),
            .step (sar_step[g]),
            .keep (cmp_gt),
            .code (sar_code[g]),
            .last (sar_last[g])
        );
    end

    sens_thresh #(.SENS_W(SENS_W)) u_thr (
        .s0          (s0_q),
        .span        (span),
        .sens        (sens_code),
        .hot_reached (hot_reached),
        .cooled      (cooled),
        .mid_reached (mid_reached),
        .mid_passed  (mid_passed)
    );

    wait_timer #(.TW(TMO_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .lim     (tmo_lim),
        .expired (tmo)
    );

    assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERR);
    assign go        = idle_like && start;
    assign tmr_en    = (state_q == ST_I_HEAT) || (state_q == ST_I_COOL);
    assign tmr_clr   = (state_d != state_q);

    assign sar_init[IX_I] = go;
    assign sar_step[IX_I] = (state_q == ST_I_VERD) && cmp_valid;
    assign sar_init[IX_L] = (state_q == ST_L_ARM) && mid_reached;
    assign sar_step[IX_L] = (state_q == ST_L_VERD) && cmp_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ERR: if (start) state_d = ST_I_LO;
            ST_I_LO:   state_d = ST_I_HEAT;
            ST_I_HEAT: begin
                if (hot_reached)  state_d = ST_I_HI;
                else if (tmo)     state_d = ST_ERR;
            end
            ST_I_HI:   state_d = ST_I_VERD;
            ST_I_VERD: if (cmp_valid) state_d = ST_I_COOL;
            ST_I_COOL: begin
                if (cooled)       state_d = infl_fin_q ? ST_L_ARM : ST_I_LO;
                else if (tmo)     state_d = ST_ERR;
            end
            ST_L_ARM:  if (mid_reached) state_d = ST_L_OLD;
            ST_L_OLD:  state_d = ST_L_NEW;
            ST_L_NEW:  state_d = ST_L_VERD;
            ST_L_VERD: if (cmp_valid) state_d = sar_last[IX_L] ? ST_SWITCH : ST_L_OLD;
            ST_SWITCH: if (mid_passed) state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and run data
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            s0_q       <= '0;
            cur_infl_q <= DEF_INFL;
            cur_lvl_q  <= DEF_LVL;
            infl_fin_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (go) begin
                s0_q       <= sens_code;
                infl_fin_q <= 1'b0;
            end
            if (sar_step[IX_I]) infl_fin_q <= sar_last[IX_I];
            if ((state_q == ST_SWITCH) && mid_passed) begin
                cur_infl_q <= sar_code[IX_I];
                cur_lvl_q  <= sar_code[IX_L];
            end
        end
    end

    // outputs
    always_comb begin
        heat_en    = 1'b0;
        req_first  = 1'b0;
        req_second = 1'b0;
        busy       = !idle_like;
        done       = (state_q == ST_DONE);
        err        = (state_q == ST_ERR);
        infl_trim  = cur_infl_q;
        lvl_trim   = cur_lvl_q;
        unique case (state_q)
            ST_I_LO: begin
                req_first = 1'b1;
                infl_trim = sar_code[IX_I];
            end
            ST_I_HEAT: begin
                heat_en   = 1'b1;
                infl_trim = sar_code[IX_I];
            end
            ST_I_HI: begin
                req_second = 1'b1;
                infl_trim  = sar_code[IX_I];
            end
            ST_I_VERD, ST_I_COOL: infl_trim = sar_code[IX_I];
            ST_L_OLD: req_first = 1'b1;
            ST_L_NEW: begin
                req_second = 1'b1;
                infl_trim  = sar_code[IX_I];
                lvl_trim   = sar_code[IX_L];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/refcal_seq_chk.sv
module refcal_seq_chk #(
    parameter int TRIM_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [TRIM_W-1:0] infl_trim,
    input logic              heat_en,
    input logic              req_first,
    input logic              req_second,
    input logic              busy,
    input logic              done,
    input logic              err
);
    localparam logic [TRIM_W-1:0] TOP = TRIM_W'(1) << (TRIM_W - 1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !heat_en && !done && !err));

    // R2
    start_trial_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (req_first && infl_trim == TOP));

    // R3
    heat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        heat_en |=> ($stable(infl_trim) || err));

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_first && req_second));

    // R9
    first_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_first |=> !req_first);

    // R9
    second_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_second |=> !req_second);

    // R9
    strobe_cool_chk: assert property (@(posedge clk) disable iff (rst)
        (req_first || req_second) |-> !heat_en);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!heat_en && !busy));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !heat_en));
endmodule

bind refcal_seq refcal_seq_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .infl_trim  (infl_trim),
    .heat_en    (heat_en),
    .req_first  (req_first),
    .req_second (req_second),
    .busy       (busy),
    .done       (done),
    .err        (err)
);

// File: tb/refcal_seq_tb_top.sv
`timescale 1ns/1ps
module refcal_seq_tb_top;
    localparam int TW = 8;
    localparam int SW = 10;
    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [SW-1:0] sens_code, span = '0;
    logic [MW-1:0] tmo_lim = 16'd2000;
    logic          cmp_valid = 1'b0, cmp_gt = 1'b0;
    logic [TW-1:0] infl_trim, lvl_trim;
    logic          heat_en, req_first, req_second, busy, done, err;

    always #4 clk = ~clk;

    refcal_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .sens_code(sens_code), .span(span),
        .tmo_lim(tmo_lim), .cmp_valid(cmp_valid), .cmp_gt(cmp_gt),
        .infl_trim(infl_trim), .lvl_trim(lvl_trim), .heat_en(heat_en),
        .req_first(req_first), .req_second(req_second), .busy(busy),
        .done(done), .err(err)
    );

    int n_chk = 0, n_fail = 0;
    int sens_i = 300, amb = 300;
    bit broken = 0;
    int nsec = 0, nfirst = 0, pend = 0;
    bit pend_v = 0;
    int s0_b = 0, sr_b = 0, ti_b = 0, tl_b = 0;
    int old_i = 'h5A, old_l = 'h33;
    int exp_i = 128, bit_i = 128, exp_l = 128, bit_l = 128;
    bit finished = 0;

    assign sens_code = SW'(sens_i);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sar_next(input int code, input int bm, input bit keep);
        int c = keep ? code : (code & ~bm);
        return c | (bm >> 1);
    endfunction

    // thermal, comparator and strobe monitor model
    initial begin
        forever begin
            @(negedge clk);
            cmp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    cmp_valid = 1'b1;
                    cmp_gt    = pend_v;
                end
            end
            if (req_first) begin
                nfirst++;
                if (nsec < TW) begin
                    check(!heat_en, "R2 heater off at first sample", int'(heat_en), 0);
                    if (nsec == 0) check(infl_trim == 8'h80, "R2 first trial", int'(infl_trim), 128);
                    check(int'(lvl_trim) == old_l, "R2 level unchanged", int'(lvl_trim), old_l);
                    check(sens_i <= s0_b, "R5 sample at baseline", sens_i, s0_b);
                    check(int'(infl_trim) == exp_i, "R4 trial code", int'(infl_trim), exp_i);
                end else begin
                    check(int'(infl_trim) == old_i && int'(lvl_trim) == old_l,
                          "R6 old codes on first level sample", int'(infl_trim), old_i);
                end
            end
            if (req_second) begin
                bit v;
                if (nsec < TW) begin
                    check(int'(infl_trim) == exp_i, "R3 trial held for hot sample", int'(infl_trim), exp_i);
                    check(sens_i >= s0_b + 2 * sr_b, "R3 hot sample temperature", sens_i, s0_b + 2 * sr_b);
                    v = int'(infl_trim) <= ti_b;
                    exp_i = sar_next(exp_i, bit_i, v);
                    bit_i = bit_i >> 1;
                end else begin
                    check(int'(infl_trim) == ti_b, "R6 new inflection code", int'(infl_trim), ti_b);
                    check(int'(lvl_trim) == exp_l, "R6 level trial", int'(lvl_trim), exp_l);
                    check(sens_i >= s0_b + sr_b / 2, "R6 level step temperature", sens_i, s0_b + sr_b / 2);
                    v = int'(lvl_trim) <= tl_b;
                    exp_l = sar_next(exp_l, bit_l, v);
                    bit_l = bit_l >> 1;
                end
                nsec++;
                pend   = 3;
                pend_v = v;
            end
            if (heat_en && !broken) begin
                if (sens_i < 1023) sens_i++;
            end else if (sens_i > amb) sens_i--;
            else if (sens_i < amb) sens_i++;
        end
    end

    task automatic arm(input int ti, input int tl, input int s0, input int sr, input int lim);
        @(negedge clk);
        s0_b = s0; sr_b = sr; ti_b = ti; tl_b = tl;
        amb = s0; sens_i = s0; span = SW'(sr); tmo_lim = MW'(lim);
        nsec = 0; exp_i = 128; bit_i = 128; exp_l = 128; bit_l = 128;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    endtask

    task automatic run_cal(input int ti, input int tl, input int s0, input int sr);
        int nf;
        arm(ti, tl, s0, sr, 2000);
        while (!(nsec >= TW && pend == 0)) @(negedge clk);
        while (sens_i > s0) @(negedge clk);
        repeat (3) @(negedge clk);
        nf = nfirst;
        repeat (40) @(negedge clk);
        check(nfirst == nf && busy && !heat_en, "R6 no request below half span", nfirst - nf, 0);
        check(int'(infl_trim) == old_i && int'(lvl_trim) == old_l, "R6 old codes between searches",
              int'(infl_trim), old_i);
        amb = s0 + sr / 2;
        while (!(nsec >= 2 * TW && pend == 0)) @(negedge clk);
        repeat (30) @(negedge clk);
        check(!done && busy, "R7 no switch at exact half span", int'(done), 0);
        check(int'(infl_trim) == old_i && int'(lvl_trim) == old_l, "R7 old codes held",
              int'(lvl_trim), old_l);
        amb = s0 + sr / 2 + 2;
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
        check(done && !busy, "R7 done after passing half span", int'(done), 1);
        check(int'(infl_trim) == ti, "R4 inflection result", int'(infl_trim), ti);
        check(int'(lvl_trim) == tl, "R6 level result", int'(lvl_trim), tl);
        old_i = ti; old_l = tl;
    endtask

    initial begin
        int rv;
        rv = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !heat_en && !done && !err, "R1 reset flags", int'(busy), 0);
        check(infl_trim == 8'h5A && lvl_trim == 8'h33, "R1 reset codes", int'(infl_trim), 'h5A);

        run_cal(255, 0, 500, 8);
        run_cal(0, 255, 100, 5);
        for (int r = 0; r < 3; r++) begin
            run_cal(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    int'($urandom_range(50, 850)), int'($urandom_range(4, 20)));
        end

        // R8 dead heater times out
        begin
            int hc = 0;
            broken = 1'b1;
            arm(77, 99, 400, 6, 30);
            for (int k = 0; k < 300 && !err; k++) begin
                if (heat_en) hc++;
                @(negedge clk);
            end
            check(err && !heat_en && !busy, "R8 timeout flags", int'(err), 1);
            check(hc == 31, "R8 heater duration before abort", hc, 31);
            check(int'(infl_trim) == old_i && int'(lvl_trim) == old_l, "R8 codes restored",
                  int'(infl_trim), old_i);
            broken = 1'b0;
        end

        // R1 reset in mid-heat
        arm(10, 20, 300, 10, 2000);
        while (!heat_en) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !heat_en && !done && !err, "R1 mid-run reset flags", int'(heat_en), 0);
        check(infl_trim == 8'h5A && lvl_trim == 8'h33, "R1 mid-run reset codes", int'(lvl_trim), 'h33);
        old_i = 'h5A; old_l = 'h33;

        run_cal(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                int'($urandom_range(50, 850)), int'($urandom_range(4, 20)));

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule